// File: doc/BRIEF.md
# Hypervisor CSR Bank Swapper

This block keeps the supervisor-level control registers a hart uses while it runs, together with two shadow copies. One shadow holds the values that belong to the host supervisor. The other holds the values that belong to the guest supervisor. When the trap or return logic raises the swap strobe, the block moves the active set into one shadow and reloads the active set from the other. The current virtualization bit picks the direction. The status register is not exchanged as a whole. Only a fixed group of fields moves, through a mask-and-merge, and every other status bit stays where it is.

The block also holds the virtualization bit and the force-host-exception bit. It raises a one-cycle TLB-flush pulse whenever a write really changes the virtualization bit. A write port loads any register of any bank directly. A combinational read port returns any register of any bank. A floating-point-enabled output reflects the FS field of the active status and, while virtualized, the FS field of the host copy as well. With the hypervisor option turned off, the block keeps only the active set.

Top module: `hbank_swapper`

## Requirements
- R1: After reset, every register in all three banks reads zero, and the virtualization bit, the force bit and the flush pulse are all low.
- R2: A direct write stores data into the register chosen by the index and the bank, and the read port returns it with no delay. Index codes: 0 status, 1 trap vector, 2 scratch, 3 exception PC, 4 cause, 5 trap value, 6 translation base. Bank codes: 0 active, 1 host shadow, 2 guest shadow. Index 7 and bank 3 read as zero and ignore writes.
- R3: A swap while virtualized stores status AND mask into the guest status. The active status becomes (status AND NOT mask) OR host status. The host status is left unchanged.
- R4: A swap while not virtualized stores status AND mask into the host status. The active status becomes (status AND NOT mask) OR guest status. The guest status is left unchanged.
- R5: The mask holds status bits 1, 5, 8, 13, 14, 18 and 19. With XLEN of 64 it also holds bits 32 and 33.
- R6: For indices 1 to 6, a swap while virtualized copies active into guest and host into active. A swap while not virtualized copies active into host and guest into active. The shadow being read is left unchanged.
- R7: A virtualization write takes effect on the next edge. The flush output is high for exactly the cycle after any edge where that write changed the bit. It stays low when the written value equals the current value.
- R8: A force-bit write sets the force output on the next edge. The force bit holds its value until the next force-bit write.
- R9: With the hypervisor option off, the virtualization and force outputs stay zero and the flush output never rises. Both shadow banks read zero and ignore writes, and swaps have no effect.
- R10: Floating point is reported enabled when the active status field at bits 14:13 is nonzero and, while virtualized, the host status bits 14:13 are also nonzero.
- R11: When a swap and a virtualization write fall on the same edge, the swap direction follows the virtualization value from before that edge.
- R12: A swap and a direct write must never be asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| swap_i | input | 1 | Bank exchange strobe |
| wr_en_i | input | 1 | Direct register write enable |
| wr_bank_i | input | 2 | Bank selected for the write |
| wr_idx_i | input | 3 | Register index selected for the write |
| wr_data_i | input | XLEN | Write data |
| virt_we_i | input | 1 | Virtualization bit write enable |
| virt_val_i | input | 1 | New virtualization value |
| force_we_i | input | 1 | Force-host-exception bit write enable |
| force_val_i | input | 1 | New force bit value |
| rd_bank_i | input | 2 | Bank selected for reading |
| rd_idx_i | input | 3 | Register index selected for reading |
| rd_data_o | output | XLEN | Read data |
| virt_o | output | 1 | Virtualization bit |
| force_hs_o | output | 1 | Force-host-exception bit |
| fp_en_o | output | 1 | Floating point enabled indication |
| tlb_flush_o | output | 1 | One-cycle flush request |

## Verification
A swap and a virtualization write can land on the same clock edge. The swap must then take its direction from the old virtualization value, while the flush pulse reports the change. The bench produces this collision both in directed sequences and in random ones, with the virtualization value flipped and with it unchanged. It then sweeps all three banks and compares each one against a model that applies the swap before it updates the virtualization bit.

// File: rtl/hbank_pkg.sv
package hbank_pkg;

   localparam int NUM_REGS = 7;
   localparam int IDX_W    = 3;
   localparam int FS_LO    = 13;
   localparam int FS_HI    = 14;

   typedef enum logic [1:0] {
      BANK_ACT  = 2'd0,
      BANK_HS   = 2'd1,
      BANK_GST  = 2'd2,
      BANK_NONE = 2'd3
   } bank_e;

   // Status fields that travel with the supervisor context.
   function automatic logic [63:0] swap_mask(input int unsigned xlen);
      logic [63:0] m;
      m        = '0;
      m[1]     = 1'b1;   // supervisor interrupt enable
      m[5]     = 1'b1;   // previous interrupt enable
      m[8]     = 1'b1;   // previous privilege
      m[14:13] = 2'b11;  // floating point state
      m[18]    = 1'b1;   // user memory access permit
      m[19]    = 1'b1;   // executable readable
      if (xlen == 64) m[33:32] = 2'b11; // user xlen field
      return m;
   endfunction

endpackage

// File: rtl/hbank_lane.sv
module hbank_lane #(
   parameter int               XLEN  = 64,
   parameter logic [XLEN-1:0]  MERGE = {XLEN{1'b1}}
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            swap_i,
   input  logic            virt_i,
   input  logic            we_act_i,
   input  logic            we_hs_i,
   input  logic            we_gst_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] act_o,
   output logic [XLEN-1:0] hs_o,
   output logic [XLEN-1:0] gst_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_o <= '0;
         hs_o  <= '0;
         gst_o <= '0;
      end else if (swap_i) begin
         if (virt_i) begin
            gst_o <= act_o & MERGE;
            act_o <= (act_o & ~MERGE) | hs_o;
         end else begin
            hs_o  <= act_o & MERGE;
            act_o <= (act_o & ~MERGE) | gst_o;
         end
      end else begin
         if (we_act_i) act_o <= wdata_i;
         if (we_hs_i)  hs_o  <= wdata_i;
         if (we_gst_i) gst_o <= wdata_i;
      end
   end

   AST_LEAVE_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swap_i && virt_i) |=> (gst_o == ($past(act_o) & MERGE)));  // R3, R6
   AST_LEAVE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swap_i && virt_i) |=> $stable(hs_o));                      // R3, R6
   AST_ENTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swap_i && !virt_i) |=> (hs_o == ($past(act_o) & MERGE)));  // R4, R6
   AST_ENTER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swap_i && !virt_i) |=> $stable(gst_o));                    // R4, R6

endmodule

// File: rtl/hbank_virt_ctl.sv
module hbank_virt_ctl #(
   parameter bit HAS_H = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic virt_we_i,
   input  logic virt_val_i,
   input  logic force_we_i,
   input  logic force_val_i,
   output logic virt_o,
   output logic force_o,
   output logic flush_o
);

   generate
      if (HAS_H) begin : g_hyp
         logic virt_q, force_q, flush_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               virt_q  <= 1'b0;
               force_q <= 1'b0;
               flush_q <= 1'b0;
            end else begin
               flush_q <= virt_we_i && (virt_val_i != virt_q);
               if (virt_we_i)  virt_q  <= virt_val_i;
               if (force_we_i) force_q <= force_val_i;
            end
         end

         assign virt_o  = virt_q;
         assign force_o = force_q;
         assign flush_o = flush_q;

         AST_FLUSH_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (virt_q != $past(virt_q)) |-> flush_q);                 // R7
         AST_FLUSH_ONLY_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            flush_q |-> (virt_q != $past(virt_q)));                 // R7
         AST_FORCE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !force_we_i |=> $stable(force_q));                      // R8
      end else begin : g_plain
         assign virt_o  = 1'b0;
         assign force_o = 1'b0;
         assign flush_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hbank_swapper.sv
module hbank_swapper #(
   parameter int XLEN  = 64,
   parameter bit HAS_H = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       swap_i,
   input  logic                       wr_en_i,
   input  logic [1:0]                 wr_bank_i,
   input  logic [hbank_pkg::IDX_W-1:0] wr_idx_i,
   input  logic [XLEN-1:0]            wr_data_i,
   input  logic                       virt_we_i,
   input  logic                       virt_val_i,
   input  logic                       force_we_i,
   input  logic                       force_val_i,
   input  logic [1:0]                 rd_bank_i,
   input  logic [hbank_pkg::IDX_W-1:0] rd_idx_i,
   output logic [XLEN-1:0]            rd_data_o,
   output logic                       virt_o,
   output logic                       force_hs_o,
   output logic                       fp_en_o,
   output logic                       tlb_flush_o
);
   import hbank_pkg::*;

   localparam logic [XLEN-1:0] STATUS_MASK = XLEN'(swap_mask(XLEN));
   localparam logic [XLEN-1:0] FULL_MASK   = {XLEN{1'b1}};
   localparam bit              SHADOWS_ON  = HAS_H;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("hbank_swapper: XLEN must be 32 or 64");
      end
      if (NUM_REGS > (1 << IDX_W)) begin : g_bad_idx
         $error("hbank_swapper: index width too small");
      end
   endgenerate

   logic [XLEN-1:0] act_v [NUM_REGS];
   logic [XLEN-1:0] hs_v  [NUM_REGS];
   logic [XLEN-1:0] gst_v [NUM_REGS];
   logic            swap_en;

   assign swap_en = swap_i && SHADOWS_ON;

   hbank_virt_ctl #(.HAS_H(HAS_H)) u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .virt_we_i   (virt_we_i),
      .virt_val_i  (virt_val_i),
      .force_we_i  (force_we_i),
      .force_val_i (force_val_i),
      .virt_o      (virt_o),
      .force_o     (force_hs_o),
      .flush_o     (tlb_flush_o)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_lane
      localparam logic [XLEN-1:0] LANE_MASK = (i == 0) ? STATUS_MASK : FULL_MASK;
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == IDX_W'(i));

      hbank_lane #(.XLEN(XLEN), .MERGE(LANE_MASK)) u_lane (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .swap_i   (swap_en),
         .virt_i   (virt_o),
         .we_act_i (hit && (wr_bank_i == BANK_ACT)),
         .we_hs_i  (hit && (wr_bank_i == BANK_HS)  && SHADOWS_ON),
         .we_gst_i (hit && (wr_bank_i == BANK_GST) && SHADOWS_ON),
         .wdata_i  (wr_data_i),
         .act_o    (act_v[i]),
         .hs_o     (hs_v[i]),
         .gst_o    (gst_v[i])
      );
   end

   always_comb begin
      rd_data_o = '0;
      if (int'(rd_idx_i) < NUM_REGS) begin
         case (rd_bank_i)
            BANK_ACT: rd_data_o = act_v[rd_idx_i];
            BANK_HS:  rd_data_o = hs_v[rd_idx_i];
            BANK_GST: rd_data_o = gst_v[rd_idx_i];
            default:  rd_data_o = '0;
         endcase
      end
   end

   assign fp_en_o = (act_v[0][FS_HI:FS_LO] != 2'b00) &&
                    (!virt_o || (hs_v[0][FS_HI:FS_LO] != 2'b00));

   AST_SWAP_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(swap_i && wr_en_i));                                         // R12
   AST_NOSWAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!swap_i && !wr_en_i) |=> $stable(act_v[0]));                  // R2

endmodule

// File: tb/hbank_swapper_test.sv
`timescale 1ns/100ps
module hbank_swapper_test;

   localparam int XLEN = 64;
   localparam logic [63:0] MASK = 64'h0000_0003_000C_6122;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic swap = 1'b0, wr_en = 1'b0, vwe = 1'b0, vval = 1'b0, fwe = 1'b0, fval = 1'b0;
   logic [1:0] wr_bank = '0, rd_bank = '0;
   logic [2:0] wr_idx = '0, rd_idx = '0;
   logic [XLEN-1:0] wr_data = '0;
   logic [XLEN-1:0] rd_data, rd_data_n;
   logic virt, frc, fp_en, flush;
   logic virt_n, frc_n, fp_en_n, flush_n;

   int checks = 0, errors = 0, overlap = 0;
   logic [63:0] e_act [7];
   logic [63:0] e_hs  [7];
   logic [63:0] e_gst [7];
   logic [63:0] n_act [7];
   logic e_virt = 1'b0, e_force = 1'b0, e_flush = 1'b0;

   always #2.5 clk = ~clk;

   hbank_swapper #(.XLEN(XLEN), .HAS_H(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_n), .swap_i(swap), .wr_en_i(wr_en),
      .wr_bank_i(wr_bank), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .virt_we_i(vwe), .virt_val_i(vval), .force_we_i(fwe), .force_val_i(fval),
      .rd_bank_i(rd_bank), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .virt_o(virt), .force_hs_o(frc), .fp_en_o(fp_en), .tlb_flush_o(flush));

   hbank_swapper #(.XLEN(XLEN), .HAS_H(1'b0)) uut_noh (
      .clk_i(clk), .rst_ni(rst_n), .swap_i(swap), .wr_en_i(wr_en),
      .wr_bank_i(wr_bank), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .virt_we_i(vwe), .virt_val_i(vval), .force_we_i(fwe), .force_val_i(fval),
      .rd_bank_i(rd_bank), .rd_idx_i(rd_idx), .rd_data_o(rd_data_n),
      .virt_o(virt_n), .force_hs_o(frc_n), .fp_en_o(fp_en_n), .tlb_flush_o(flush_n));

   always @(posedge clk) if (swap && wr_en) overlap++;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_rd(input int b, input int i, input bit noh);
      if (i >= 7 || b == 3) return '0;
      if (noh) return (b == 0) ? n_act[i] : 64'd0;
      case (b)
         0: return e_act[i];
         1: return e_hs[i];
         default: return e_gst[i];
      endcase
   endfunction

   function automatic logic exp_fp(input logic [63:0] st, input logic [63:0] hs, input logic v);
      return (st[14:13] != 2'b00) && (!v || hs[14:13] != 2'b00);
   endfunction

   task automatic sweep(input string req);
      for (int b = 0; b < 4; b++) begin
         for (int i = 0; i < 8; i++) begin
            rd_bank = 2'(b);
            rd_idx  = 3'(i);
            #1;
            chk(req, rd_data, exp_rd(b, i, 1'b0));
            chk("R9", rd_data_n, exp_rd(b, i, 1'b1));
         end
      end
   endtask

   task automatic step(input bit sw, input bit we, input logic [1:0] bk, input logic [2:0] ix,
                       input logic [63:0] d, input bit vw, input bit vv, input bit fw, input bit fv);
      @(negedge clk);
      swap = sw; wr_en = we; wr_bank = bk; wr_idx = ix; wr_data = d;
      vwe = vw; vval = vv; fwe = fw; fval = fv;
      @(posedge clk);
      // model: swap direction from the value before this edge (R11)
      if (sw) begin
         for (int i = 0; i < 7; i++) begin
            logic [63:0] m;
            m = (i == 0) ? MASK : 64'hFFFF_FFFF_FFFF_FFFF;
            if (e_virt) begin
               e_gst[i] = e_act[i] & m;
               e_act[i] = (e_act[i] & ~m) | e_hs[i];
            end else begin
               e_hs[i]  = e_act[i] & m;
               e_act[i] = (e_act[i] & ~m) | e_gst[i];
            end
         end
      end else if (we && ix < 7) begin
         case (bk)
            2'd0: e_act[ix] = d;
            2'd1: e_hs[ix]  = d;
            2'd2: e_gst[ix] = d;
            default: ;
         endcase
      end
      if (!sw && we && ix < 7 && bk == 2'd0) n_act[ix] = d;
      e_flush = vw && (vv != e_virt);
      if (vw) e_virt = vv;
      if (fw) e_force = fv;
      @(negedge clk);
      swap = 1'b0; wr_en = 1'b0; vwe = 1'b0; fwe = 1'b0;
      chk("R7 virt", 64'(virt), 64'(e_virt));
      chk("R7 flush", 64'(flush), 64'(e_flush));
      chk("R8 force", 64'(frc), 64'(e_force));
      chk("R10 fp", 64'(fp_en), 64'(exp_fp(e_act[0], e_hs[0], e_virt)));
      chk("R9 virt", 64'(virt_n), 64'd0);
      chk("R9 force", 64'(frc_n), 64'd0);
      chk("R9 flush", 64'(flush_n), 64'd0);
      chk("R9 fp", 64'(fp_en_n), 64'(exp_fp(n_act[0], 64'd0, 1'b0)));
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      for (int i = 0; i < 7; i++) begin
         e_act[i] = '0; e_hs[i] = '0; e_gst[i] = '0; n_act[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 virt", 64'(virt), 64'd0);
      chk("R1 force", 64'(frc), 64'd0);
      chk("R1 flush", 64'(flush), 64'd0);
      sweep("R1");

      // R2: direct writes, ignored index and bank
      for (int i = 0; i < 7; i++) step(0, 1, 2'd0, 3'(i), rnd64(), 0, 0, 0, 0);
      for (int i = 0; i < 7; i++) step(0, 1, 2'd1, 3'(i), rnd64(), 0, 0, 0, 0);
      for (int i = 0; i < 7; i++) step(0, 1, 2'd2, 3'(i), rnd64(), 0, 0, 0, 0);
      step(0, 1, 2'd3, 3'd1, 64'hDEAD_BEEF_0000_0001, 0, 0, 0, 0);
      step(0, 1, 2'd0, 3'd7, 64'hDEAD_BEEF_0000_0002, 0, 0, 0, 0);
      sweep("R2");

      // R5: mask positions through a leaving swap
      step(0, 1, 2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
      step(0, 1, 2'd1, 3'd0, 64'd0, 0, 0, 0, 0);
      step(0, 0, 2'd0, 3'd0, 64'd0, 1, 1, 0, 0);
      step(1, 0, 2'd0, 3'd0, 64'd0, 0, 0, 0, 0);
      rd_bank = 2'd2; rd_idx = 3'd0; #1;
      chk("R5 guest status", rd_data, MASK);
      rd_bank = 2'd0; #1;
      chk("R5 active status", rd_data, ~MASK);
      sweep("R3");

      // R4: entering swap
      step(0, 0, 2'd0, 3'd0, 64'd0, 1, 0, 0, 0);
      step(0, 1, 2'd2, 3'd0, rnd64(), 0, 0, 0, 0);
      step(1, 0, 2'd0, 3'd0, 64'd0, 0, 0, 0, 0);
      sweep("R4");
      sweep("R6");

      // R7: rewrite same value, no flush
      step(0, 0, 2'd0, 3'd0, 64'd0, 1, 0, 0, 0);
      step(0, 0, 2'd0, 3'd0, 64'd0, 1, 1, 0, 0);
      step(0, 0, 2'd0, 3'd0, 64'd0, 1, 1, 0, 0);

      // R10: FS zero in host copy while virtualized
      step(0, 1, 2'd1, 3'd0, 64'd0, 0, 0, 0, 0);
      step(0, 1, 2'd0, 3'd0, 64'h0000_0000_0000_6000, 0, 0, 0, 0);
      step(0, 1, 2'd1, 3'd0, 64'h0000_0000_0000_2000, 0, 0, 0, 0);

      // R11: swap together with a flipping virtualization write
      step(1, 0, 2'd0, 3'd0, 64'd0, 1, 0, 0, 0);
      sweep("R11");
      step(1, 0, 2'd0, 3'd0, 64'd0, 1, 1, 0, 0);
      sweep("R11");

      // R8: force bit
      step(0, 0, 2'd0, 3'd0, 64'd0, 0, 0, 1, 1);
      step(0, 0, 2'd0, 3'd0, 64'd0, 0, 0, 0, 0);
      step(0, 0, 2'd0, 3'd0, 64'd0, 0, 0, 1, 0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         logic [63:0] d;
         op = $urandom_range(0, 5);
         d = rnd64();
         if ($urandom_range(0, 3) == 0) d[14:13] = 2'b00;
         case (op)
            0, 1: step(0, 1, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), d, 0, 0, 0, 0);
            2: step(1, 0, 2'd0, 3'd0, 64'd0, 0, 0, 0, 0);
            3: step(0, 0, 2'd0, 3'd0, 64'd0, 1, 1'($urandom_range(0, 1)), 0, 0);
            4: step(0, 0, 2'd0, 3'd0, 64'd0, 0, 0, 1, 1'($urandom_range(0, 1)));
            default: step(1, 0, 2'd0, 3'd0, 64'd0, 1, 1'($urandom_range(0, 1)), 0, 0);
         endcase
         if (n % 8 == 0) sweep("R6");
      end
      sweep("R6");

      chk("R12 swap and write overlap", 64'(overlap), 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule